// File: doc/BRIEF.md
# Predicted End-of-Burst Generator

This block follows the transfer stream of one bus master and raises a single-cycle flag on each beat that a slave arbiter may treat as a re-arbitration point. On a fixed-length burst the flag lands on the true final beat. On a single transfer it lands on the only beat. On an undefined-length incrementing burst it lands on the last beat of each 4, 8 or 16 beat segment, or never, as set by a per-master mode field.

The flag is combinational from the current beat. It rises in the same cycle as the accepted beat it marks, so an arbiter sampling it at the clock edge can hand the bus over for the next address phase. A small tracker holds the beat count and the burst type and mode that were seen when the burst started.

Top module: `pred_eob_gen`

## Requirements
- R1: After reset, the flag is low on idle cycles. A sequential beat that follows reset without a nonsequential start is treated as an undefined-length burst with no breaks, and never raises the flag.
- R2: A nonsequential, accepted beat with burst code 0 (single) raises the flag in that cycle.
- R3: Burst codes 2 (4-beat wrapping) and 3 (4-beat incrementing) raise the flag on the 4th accepted beat only.
- R4: Burst codes 4 and 5 (8-beat) raise the flag on the 8th accepted beat only. Burst codes 6 and 7 (16-beat) raise it on the 16th accepted beat only.
- R5: For burst codes 0 and 2 to 7, the undefined-length mode field has no effect on the flag.
- R6: With burst code 1 (undefined-length incrementing) and mode 0, the flag never rises, however long the burst is.
- R7: With burst code 1 and mode 1, the flag rises on accepted beats 4, 8, 12, and so on.
- R8: With burst code 1, mode 2 raises the flag on every 8th accepted beat and mode 3 on every 16th.
- R9: Busy (transfer code 1) and idle (code 0) cycles never raise the flag and do not advance the beat count.
- R10: A cycle with beat_ok low never raises the flag and does not advance the beat count.
- R11: A nonsequential beat (code 2) always starts counting again from the first beat, even in the middle of a burst.
- R12: The burst type and mode are taken at the nonsequential beat. A change of the mode input during the sequential beats (code 3) has no effect until the next nonsequential beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trans | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonsequential, 3 sequential |
| burst | input | 3 | Burst type: 0 single, 1 undefined incr, 2/3 4-beat wrap/incr, 4/5 8-beat, 6/7 16-beat |
| beat_ok | input | 1 | The current beat is accepted this cycle |
| incr_mode | input | 2 | Undefined-length break mode: 0 never, 1 every 4, 2 every 8, 3 every 16 |
| eob | output | 1 | Predicted end of burst on this beat |

## Verification
The stimulus covers each burst kind: single, 4-beat wrap, 8-beat wrap, 4-beat incr, 8-beat incr, 16-beat incr and 16-beat wrap. It also runs undefined-length bursts under all four modes. Comparing a fixed burst run under a non-zero mode against the same run under mode 0 shows whether the fixed count ignores the mode. The long runs under modes 2, 3 and 0 tell a correct segment width apart from an off-by-one or from wrapping at the counter width. Wait states, busy beats and mid-burst restarts are placed next to boundary beats, so a count that slips by one cycle moves the flag to a visible wrong beat. A mode change mid-burst shows whether the mode is latched at the start of the burst.

// File: rtl/pred_eob_pkg.sv
package pred_eob_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_BUSY = 2'd1,
        TR_NSEQ = 2'd2,
        TR_SEQ  = 2'd3
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_WRAP4  = 3'd2,
        BT_INCR4  = 3'd3,
        BT_WRAP8  = 3'd4,
        BT_INCR8  = 3'd5,
        BT_WRAP16 = 3'd6,
        BT_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        SEG_NEVER = 2'd0,
        SEG_4     = 2'd1,
        SEG_8     = 2'd2,
        SEG_16    = 2'd3
    } seg_mode_e;

endpackage

// File: rtl/eob_len_decode.sv
module eob_len_decode
    import pred_eob_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  burst_e            kind,
    input  seg_mode_e         mode,
    output logic [CNT_W-1:0]  mask,
    output logic              open_ended
);

    // Base-2 log of the segment length; every length is a power of two,
    // so the end beat is the one whose low index bits are all ones.
    logic [2:0] len_log;

    always_comb begin
        open_ended = 1'b0;
        unique case (kind)
            BT_SINGLE:           len_log = 3'd0;
            BT_WRAP4, BT_INCR4:  len_log = 3'd2;
            BT_WRAP8, BT_INCR8:  len_log = 3'd3;
            BT_WRAP16, BT_INCR16: len_log = 3'd4;
            default: begin
                unique case (mode)
                    SEG_4:   len_log = 3'd2;
                    SEG_8:   len_log = 3'd3;
                    SEG_16:  len_log = 3'd4;
                    default: begin
                        len_log    = 3'd0;
                        open_ended = 1'b1;
                    end
                endcase
            end
        endcase
        mask = CNT_W'((32'd1 << len_log) - 32'd1);
    end

endmodule

// File: rtl/eob_beat_track.sv
module eob_beat_track
    import pred_eob_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adv,
    input  burst_e            kind_in,
    input  seg_mode_e         mode_in,
    output logic [CNT_W-1:0]  idx,
    output burst_e            cur_kind,
    output seg_mode_e         cur_mode
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        burst_e           kind;
        seg_mode_e        mode;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        idx      = start ? '0 : trk_q.cnt;
        cur_kind = start ? kind_in : trk_q.kind;
        cur_mode = start ? mode_in : trk_q.mode;
        if (start) begin
            trk_d.kind = kind_in;
            trk_d.mode = mode_in;
            trk_d.cnt  = '0;
        end
        if (adv) begin
            trk_d.cnt = idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{cnt: '0, kind: BT_INCR, mode: SEG_NEVER};
        end else begin
            trk_q <= trk_d;
        end
    end

    assert_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !start) |=> $stable(trk_q.cnt))
        else $error("beat count moved without an accepted beat");

    assert_restart_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && adv) |=> (trk_q.cnt == CNT_W'(1)))
        else $error("nonsequential beat did not restart the count");

    assert_mode_latched_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(trk_q.mode))
        else $error("mode changed outside a burst start");

endmodule

// File: rtl/pred_eob_gen.sv
module pred_eob_gen
    import pred_eob_pkg::*;
#(
    parameter int MAX_BEATS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] trans,
    input  logic [2:0] burst,
    input  logic       beat_ok,
    input  logic [1:0] incr_mode,
    output logic       eob
);

    // The counter must span the longest segment (16 beats).
    localparam int CNT_W = (MAX_BEATS < 16) ? 4 : $clog2(MAX_BEATS);

    trans_e             trans_t;
    logic               start;
    logic               adv;
    logic [CNT_W-1:0]   idx;
    logic [CNT_W-1:0]   mask;
    logic               open_ended;
    burst_e             cur_kind;
    seg_mode_e          cur_mode;

    assign trans_t = trans_e'(trans);
    assign start   = (trans_t == TR_NSEQ);
    assign adv     = beat_ok && (trans_t == TR_NSEQ || trans_t == TR_SEQ);

    eob_beat_track #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .adv      (adv),
        .kind_in  (burst_e'(burst)),
        .mode_in  (seg_mode_e'(incr_mode)),
        .idx      (idx),
        .cur_kind (cur_kind),
        .cur_mode (cur_mode)
    );

    eob_len_decode #(.CNT_W(CNT_W)) u_decode (
        .kind       (cur_kind),
        .mode       (cur_mode),
        .mask       (mask),
        .open_ended (open_ended)
    );

    always_comb begin
        eob = adv && !open_ended && ((idx & mask) == mask);
    end

    assert_eob_on_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eob |-> (beat_ok && trans[1]))
        else $error("flag raised without an accepted active beat");

    assert_single_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trans == 2'd2 && burst == 3'd0 && beat_ok) |-> eob)
        else $error("single transfer missed its flag");

    assert_never_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trans == 2'd3 && cur_kind == BT_INCR && cur_mode == SEG_NEVER) |-> !eob)
        else $error("flag raised in never-break mode");

endmodule

// File: tb/test_pred_eob_gen.sv
`timescale 1ns/1ps
module test_pred_eob_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] trans = 2'd0;
    logic [2:0] burst = 3'd0;
    logic       beat_ok = 1'b0;
    logic [1:0] incr_mode = 2'd0;
    logic       eob;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pred_eob_gen i_pred_eob_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .trans     (trans),
        .burst     (burst),
        .beat_ok   (beat_ok),
        .incr_mode (incr_mode),
        .eob       (eob)
    );

    typedef struct packed {
        logic [1:0] t;
        logic [2:0] b;
        logic       ok;
        logic [1:0] m;
        logic       e;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 1'b1, 2'd0, 1'b0, 4'd1},   // R1 idle
        '{2'd2, 3'd0, 1'b1, 2'd0, 1'b1, 4'd2},   // R2 single
        '{2'd2, 3'd3, 1'b1, 2'd0, 1'b0, 4'd3},   // R3 INCR4, mode 0
        '{2'd3, 3'd3, 1'b1, 2'd0, 1'b0, 4'd3},
        '{2'd3, 3'd3, 1'b1, 2'd0, 1'b0, 4'd3},
        '{2'd3, 3'd3, 1'b1, 2'd0, 1'b1, 4'd3},
        '{2'd2, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},   // R5 WRAP8 under mode 1
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},   // 4th beat: no break
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b0, 4'd5},
        '{2'd3, 3'd4, 1'b1, 2'd1, 1'b1, 4'd4},   // R4 8th beat
        '{2'd2, 3'd2, 1'b1, 2'd2, 1'b0, 4'd3},   // R3 WRAP4
        '{2'd3, 3'd2, 1'b0, 2'd2, 1'b0, 4'd10},  // R10 wait state
        '{2'd3, 3'd2, 1'b1, 2'd2, 1'b0, 4'd10},
        '{2'd3, 3'd2, 1'b1, 2'd2, 1'b0, 4'd3},
        '{2'd3, 3'd2, 1'b1, 2'd2, 1'b1, 4'd3},
        '{2'd2, 3'd1, 1'b1, 2'd1, 1'b0, 4'd7},   // R7 INCR mode 1
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd7},
        '{2'd1, 3'd1, 1'b1, 2'd1, 1'b0, 4'd9},   // R9 busy
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd9},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b1, 4'd7},
        '{2'd0, 3'd1, 1'b1, 2'd1, 1'b0, 4'd9},   // R9 idle gap
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd9},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd7},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd7},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b1, 4'd7},   // 8th beat
        '{2'd2, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},  // R11 restart mid-burst
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},
        '{2'd2, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b0, 4'd11},
        '{2'd3, 3'd1, 1'b1, 2'd1, 1'b1, 4'd11},
        '{2'd2, 3'd0, 1'b1, 2'd3, 1'b1, 4'd5}    // R5 single under mode 3
    };

    task automatic check(input logic exp, input string tag);
        checks++;
        if (eob !== exp) begin
            failures++;
            $display("FAIL %s: eob=%b expected=%b", tag, eob, exp);
        end
    endtask

    // Drive one beat after the falling edge, check before the rising edge.
    task automatic beat(input logic [1:0] t, input logic [2:0] b, input logic ok,
                        input logic [1:0] m, input logic exp, input string tag);
        @(negedge clk);
        trans = t; burst = b; beat_ok = ok; incr_mode = m;
        #1;
        check(exp, tag);
    endtask

    // Full burst of n accepted beats; flag expected where (i+1) % period == 0.
    task automatic run_burst(input logic [2:0] b, input logic [1:0] m, input int n,
                             input int period, input string tag);
        for (int i = 0; i < n; i++) begin
            beat((i == 0) ? 2'd2 : 2'd3, b, 1'b1, m,
                 (period != 0) && (((i + 1) % period) == 0), tag);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: eob=%b expected=finish", eob);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VECS[k]) begin
            beat(VECS[k].t, VECS[k].b, VECS[k].ok, VECS[k].m, VECS[k].e,
                 $sformatf("R%0d vec %0d", VECS[k].req, k));
        end

        // R4 fixed 16-beat bursts, mode set to 1 to expose misuse
        run_burst(3'd7, 2'd1, 16, 16, "R4 INCR16");
        run_burst(3'd6, 2'd1, 16, 16, "R4 WRAP16");
        run_burst(3'd5, 2'd3, 8, 8, "R4 INCR8 mode 3");
        // R8 undefined-length at 8 and 16 beat segments
        run_burst(3'd1, 2'd2, 24, 8, "R8 mode 2");
        run_burst(3'd1, 2'd3, 32, 16, "R8 mode 3");
        // R6 never-break mode over a long burst
        run_burst(3'd1, 2'd0, 40, 0, "R6 mode 0");

        // R12 mode change mid-burst ignored until next start
        beat(2'd2, 3'd1, 1'b1, 2'd1, 1'b0, "R12 start mode 1");
        beat(2'd3, 3'd1, 1'b1, 2'd0, 1'b0, "R12 mode dropped");
        beat(2'd3, 3'd1, 1'b1, 2'd0, 1'b0, "R12 mode dropped");
        beat(2'd3, 3'd1, 1'b1, 2'd0, 1'b1, "R12 still breaks at 4");
        beat(2'd2, 3'd1, 1'b1, 2'd0, 1'b0, "R12 new start mode 0");
        for (int i = 0; i < 7; i++) beat(2'd3, 3'd1, 1'b1, 2'd1, 1'b0, "R12 mode 1 ignored");

        // R1 reset in mid-burst, then sequential beats with no start
        beat(2'd2, 3'd3, 1'b1, 2'd1, 1'b0, "R1 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        trans = 2'd0;
        #1;
        check(1'b0, "R1 idle in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) beat(2'd3, 3'd3, 1'b1, 2'd1, 1'b0, "R1 seq without start");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule